// File: doc/BRIEF.md
# MDIO Management Frame Shift Engine

The block moves one PHY management transaction over a two-wire management bus. The host loads a 32-bit command word into a single maintenance register. That write starts the transaction. The engine derives a management clock from the system clock. It first sends a run of ones on the data line. It then rotates the register once per management clock period: the top bit goes out on the line and the bottom bit is refilled from the line.

When all 32 positions have gone round, every bit is back where the host put it. For a read, the low 16 bits now hold what the PHY returned. The host can read the register at any time. During a transaction it sees the partly rotated word. An idle status bit and a one-clock completion interrupt tell the host when the result is ready.

The same register serves both the short (clause 22) and the extended (clause 45) frame styles. The host picks the style with the bit-30 select and the opcode bits.

Top module: `mdio_shift_top`

## Requirements
- R1: After reset the register reads 0, `busy_o`, `irq_o`, `mdc_o` and `mdio_oe_o` are low, and `idle_o` is high.
- R2: `mdc_o` has a period of D = 8 << `div_sel_i` system clocks (div_sel 0..3 gives 8, 16, 32 or 64), high and low for D/2 clocks each, and stays low while idle. `div_sel_i` is captured when a transaction starts.
- R3: A transaction lasts 64 `mdc_o` periods. Periods 0..31 drive 1. Periods 32..63 drive register bits 31 down to 0, most significant first. The line changes only on the falling edge of `mdc_o`. Word layout: bit 31 must-be-zero, bit 30 clause-22 select, bits 29:28 opcode, bits 27:23 PHY address, bits 22:18 register address, bits 17:16 turnaround (written as 2'b10), bits 15:0 data.
- R4: When bit 29 of the written word is 1, `mdio_oe_o` is low for periods 46..63 (bits 17..0). This covers clause 22 read 0110, clause 45 read 0011 and clause 45 read-with-increment 0010 in bits 31:28. Otherwise `mdio_oe_o` is high for all 64 periods. While idle it is low.
- R5: In each shift period, `mdio_i` is sampled at the rising edge of `mdc_o` and enters bit 0 at the following falling edge. After completion the register holds the written word. For a read, bits 17:0 instead hold the 18 values sampled from the line.
- R6: During a transaction `rd_data_o` shows the live register. After k completed shifts without line contention, it equals the written word rotated left by k.
- R7: `busy_o` falls and `irq_o` is high for exactly one system clock at the end of the 64th `mdc_o` period, which is 64·D clocks after the write edge. `idle_o` is the inverse of `busy_o`.
- R8: A write while `busy_o` is high is ignored. It has no effect on the frame, the timing or the final register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe for the maintenance register |
| wr_data_i | input | 32 | Host write data |
| div_sel_i | input | 2 | Management clock divider select (D = 8 << value) |
| rd_data_o | output | 32 | Live register contents |
| busy_o | output | 1 | Transaction in progress |
| idle_o | output | 1 | Status bit: no transaction in progress |
| irq_o | output | 1 | One-clock completion pulse |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | Sampled management data line |
| mdio_o | output | 1 | Driven management data value |
| mdio_oe_o | output | 1 | Management data output enable |

## Verification
The case hardest to reach from the ports is the hand-over of line ownership in the turnaround of a read. The engine must release the line at bit 17 while the PHY only starts driving at bit 16. The released bit must then be captured as the pulled-up value, without corrupting the rotation. The bench's responder models a pulled-up line: it counts falling edges of the management clock, leaves bit 17 undriven, drives 0 for bit 16, then drives a per-run data pattern. It does this for every opcode at every divider setting. A mid-transaction read after eight shifts and a rejected write injected while busy are folded into each run, so both are checked across all timings.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned PRE_LEN  = 32;
  localparam int unsigned RD_BIT   = 29;  // opcode msb: set for read-type commands
  localparam int unsigned REL_BITS = 18;  // turnaround + data released on reads

  typedef enum logic [3:0] {
    CMD_C22_RD    = 4'b0110,
    CMD_C22_WR    = 4'b0101,
    CMD_C45_RD    = 4'b0011,
    CMD_C45_WR    = 4'b0001,
    CMD_C45_RDINC = 4'b0010
  } mdio_cmd_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned DIV_SEL_W = 2,
  parameter int unsigned BASE_HALF = 4,
  localparam int unsigned HALF_MAX = BASE_HALF << ((1 << DIV_SEL_W) - 1),
  localparam int unsigned HW       = $clog2(HALF_MAX)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic                 mdc_o,
  output logic                 rise_o,
  output logic                 fall_o
);
  logic [HW-1:0] cnt_q;
  logic          mdc_q;
  logic [HW:0]   half_full;
  logic [HW-1:0] half_m1;
  logic          edge_hit;

  assign half_full = (HW+1)'(BASE_HALF) << div_sel_i;
  assign half_m1   = HW'(half_full - 1'b1);
  assign edge_hit  = en_i && (cnt_q == half_m1);
  assign rise_o    = edge_hit && !mdc_q;
  assign fall_o    = edge_hit && mdc_q;
  assign mdc_o     = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (edge_hit) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  mdc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mdc_q);

  // R2
  mdc_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !edge_hit) |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_frame_core.sv
module mdio_frame_core
  import mdio_pkg::*;
#(
  parameter int unsigned W        = REG_W,
  parameter int unsigned PRE      = PRE_LEN,
  parameter int unsigned RDB      = RD_BIT,
  parameter int unsigned REL      = REL_BITS,
  localparam int unsigned PERIODS = PRE + W,
  localparam int unsigned CW      = $clog2(PERIODS)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         mdio_i,
  output logic [W-1:0] sr_o,
  output logic         busy_o,
  output logic         irq_o,
  output logic         mdio_o,
  output logic         oe_o
);
  logic [W-1:0] sr_q;
  logic [CW-1:0] per_q;
  logic [CW:0]  np;
  logic busy_q, irq_q, mdio_q, oe_q, rd_op_q, samp_q;
  logic start, last_per, next_bit, next_oe;

  assign start    = wr_en_i && !busy_q;
  assign last_per = (int'(per_q) == PERIODS - 1);
  assign np       = {1'b0, per_q} + 1'b1;

  always_comb begin
    if (int'(np) < PRE)       next_bit = 1'b1;
    else if (int'(np) == PRE) next_bit = sr_q[W-1];
    else                      next_bit = sr_q[W-2];  // shift happens this same edge
    next_oe = !(rd_op_q && (int'(np) >= PERIODS - REL));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      per_q   <= '0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
      mdio_q  <= 1'b1;
      oe_q    <= 1'b0;
      rd_op_q <= 1'b0;
      samp_q  <= 1'b0;
    end else if (start) begin
      sr_q    <= wr_data_i;
      per_q   <= '0;
      busy_q  <= 1'b1;
      irq_q   <= 1'b0;
      mdio_q  <= 1'b1;
      oe_q    <= 1'b1;
      rd_op_q <= wr_data_i[RDB];
    end else begin
      irq_q <= 1'b0;
      if (busy_q && rise_i) samp_q <= mdio_i;
      if (busy_q && fall_i) begin
        if (int'(per_q) >= PRE) sr_q <= {sr_q[W-2:0], samp_q};
        if (last_per) begin
          busy_q <= 1'b0;
          irq_q  <= 1'b1;
          oe_q   <= 1'b0;
          mdio_q <= 1'b1;
          per_q  <= '0;
        end else begin
          per_q  <= per_q + 1'b1;
          mdio_q <= next_bit;
          oe_q   <= next_oe;
        end
      end
    end
  end

  assign sr_o   = sr_q;
  assign busy_o = busy_q;
  assign irq_o  = irq_q;
  assign mdio_o = mdio_q;
  assign oe_o   = oe_q;

  // R7
  irq_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);

  // R7
  done_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> irq_q);

  // R4
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !oe_q);

  // R3
  preamble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && int'(per_q) < PRE) |-> mdio_q);

  // R8
  busy_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(rd_op_q));
endmodule

// File: rtl/mdio_shift_top.sv
module mdio_shift_top
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_SEL_W = 2,
  parameter int unsigned BASE_HALF = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [REG_W-1:0]     wr_data_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic [REG_W-1:0]     rd_data_o,
  output logic                 busy_o,
  output logic                 idle_o,
  output logic                 irq_o,
  output logic                 mdc_o,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 mdio_oe_o
);
  logic [DIV_SEL_W-1:0] div_q;
  logic busy, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (wr_en_i && !busy)  div_q <= div_sel_i;
  end

  mdio_mdc_gen #(.DIV_SEL_W(DIV_SEL_W), .BASE_HALF(BASE_HALF)) u_mdc (
    .clk_i, .rst_ni, .en_i(busy), .div_sel_i(div_q),
    .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_core u_core (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .rise_i(rise), .fall_i(fall), .mdio_i,
    .sr_o(rd_data_o), .busy_o(busy), .irq_o,
    .mdio_o, .oe_o(mdio_oe_o)
  );

  assign busy_o = busy;
  assign idle_o = ~busy;

  // R8
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(div_q));
endmodule

// File: tb/mdio_shift_top_tb_top.sv
module mdio_shift_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0] div_sel = '0;
  logic [31:0] rd_data;
  logic busy, idle, irq, mdc, mdio_o, mdio_oe;
  logic mdio_line;

  int checks = 0, errors = 0;
  int pcnt = 0;
  int frame_err = 0, oe_err = 0;
  logic [31:0] cur_word = '0;
  logic [15:0] cur_pdata = '0;
  logic cur_rd = 1'b0;
  logic phy_en, phy_bit;

  always #5 clk = ~clk;

  mdio_shift_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .div_sel_i(div_sel), .rd_data_o(rd_data), .busy_o(busy), .idle_o(idle),
    .irq_o(irq), .mdc_o(mdc), .mdio_i(mdio_line), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe)
  );

  // responder: leaves bit 17 undriven (pull-up), drives 0 on bit 16, then data
  assign phy_en  = cur_rd && (pcnt >= 47) && (pcnt <= 63);
  assign phy_bit = (pcnt == 47) ? 1'b0 : cur_pdata[(63 - pcnt) & 15];
  assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  always @(negedge mdc) pcnt = pcnt + 1;

  always @(posedge mdc) begin
    if (busy) begin
      if ((pcnt >= 46) && cur_rd) begin
        if (mdio_oe !== 1'b0) oe_err++;
      end else begin
        if (mdio_oe !== 1'b1) oe_err++;
        if (mdio_o !== ((pcnt < 32) ? 1'b1 : cur_word[63 - pcnt])) frame_err++;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] sel, input logic [31:0] word, input logic [15:0] pdata);
    int d = 8 << sel;
    int n = 0, hi = 0;
    logic mid_done = 1'b0;
    logic [31:0] exp_fin;
    div_sel = sel;
    cur_pdata = pdata;
    cur_rd = word[29];
    cur_word = word;
    @(negedge clk);
    wr_en = 1'b1; wr_data = word;
    pcnt = 0; frame_err = 0; oe_err = 0;
    @(negedge clk);
    wr_en = 1'b0;
    div_sel = ~sel;  // must not affect the running transaction
    chk("R7 busy after write", {63'd0, busy}, 64'd1);
    while (irq !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
      if (mdc === 1'b1) hi++;
      if (n == 100) begin wr_en = 1'b1; wr_data = ~word; end
      if (n == 101) wr_en = 1'b0;
      if (!mid_done && pcnt == 40) begin
        mid_done = 1'b1;
        chk("R6 mid-shift readback", {32'd0, rd_data}, {32'd0, (word << 8) | (word >> 24)});
      end
    end
    chk("R7 duration", 64'(n), 64'(64 * d));
    chk("R2 mdc high clocks", 64'(hi), 64'(32 * d));
    chk("R7 busy cleared with irq", {62'd0, busy, idle}, 64'd1);
    chk("R3 frame bits", 64'(frame_err), 64'd0);
    chk("R4 output enable", 64'(oe_err), 64'd0);
    exp_fin = cur_rd ? {word[31:18], 2'b10, pdata} : word;
    chk("R5 R8 final register", {32'd0, rd_data}, {32'd0, exp_fin});
    @(negedge clk);
    chk("R7 irq single clock", {61'd0, irq, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] cmds [5];
    cmds[0] = 4'b0110; cmds[1] = 4'b0101; cmds[2] = 4'b0011;
    cmds[3] = 4'b0001; cmds[4] = 4'b0010;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset state", {rd_data, 26'd0, busy, irq, mdc, mdio_oe, 1'b0, idle}, 64'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 5; c++) begin
        logic [31:0] w;
        logic [15:0] pd;
        w  = {cmds[c], 5'(3 * s + c + 1), 5'(7 * c + s), 2'b10, 16'(16'h5A3C ^ (s * 1237 + c * 911))};
        pd = 16'(16'hC381 ^ (s * 4099 + c * 613));
        run_op(2'(s), w, pd);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule